// File: doc/BRIEF.md
# Floor-Rounding Integer Divider

This block divides an integer dividend by an integer divisor and returns a quotient rounded toward negative infinity, together with a remainder that carries the sign of the divisor. It does not truncate toward zero the way the native language operators do. Each operand comes with its own signedness flag, so unsigned, two's-complement and mixed operand pairs all share one datapath. Internally it runs one restoring step per clock on the operand magnitudes, then corrects the truncated result to floor form in a final combinational stage.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream. The input side accepts a new operation only when the unit is idle, so `in_ready` drops for the whole computation. The output side holds `out_valid` and the result until the consumer raises `out_ready`. A consumer that stalls therefore back-pressures the input side as well, because no new operands are taken while an unread result is waiting. A zero divisor does not raise a fault and does not take a different path.

Top module: `fdiv_floor_unit`

## Requirements
- R1: `in_ready` is high only while the unit is idle. Operands are captured on a rising edge where `in_valid` and `in_ready` are both high, and `in_valid` together with the operand pins is ignored at any other time.
- R2: Once raised, `out_valid` stays high and `out_quotient`/`out_remainder` stay constant until a rising edge with `out_ready` high. After that edge `out_valid` is low and `in_ready` is high.
- R3: `out_valid` is first seen high exactly DW clock edges after the edge that accepted the operands.
- R4: `out_quotient` is the floor of dividend/divisor, written as a DW+1-bit two's-complement value, for every signedness combination (e.g. -5/2 = -3, -5/-2 = 2, 5/2 = 2, 5/-2 = -3).
- R5: `out_remainder` equals dividend - divisor*quotient. It is VW bits wide, signed exactly when the divisor is signed, and a nonzero remainder has the sign of the divisor (e.g. -5 mod 3 = 1, -5 mod -3 = -2, 5 mod -3 = -1).
- R6: A signedness flag of 1 makes its operand two's complement and 0 makes it unsigned. A signed divisor is accepted like any other.
- R7: A zero divisor yields quotient 0 and remainder 0, with the normal handshake and latency.
- R8: The most negative signed dividend divided by signed -1 yields +2^(DW-1) in the DW+1-bit quotient, with remainder 0.
- R9: After reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands present |
| in_ready | output | 1 | Unit idle, will accept operands |
| in_dividend | input | DW | Dividend |
| in_dividend_signed | input | 1 | 1: dividend is two's complement |
| in_divisor | input | VW | Divisor |
| in_divisor_signed | input | 1 | 1: divisor is two's complement |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_quotient | output | DW+1 | Floor quotient, two's complement |
| out_remainder | output | VW | Remainder, in divisor's signedness |

## Verification
The assertions check the handshake on every cycle: `in_ready` and `out_valid` are never high together, a stalled result holds still, the result appears after a fixed number of steps, a signed nonzero remainder matches the divisor's sign, and a zero divisor gives an all-zero result. The arithmetic values can only be shown by the bench's scenarios. These compare every dividend/divisor pair at the default widths against a floor-division model, under all four signedness mixes. Separate scenarios cover the stalled-consumer case and operands driven while the unit is busy.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } fdiv_state_e;
endpackage

// File: rtl/fdiv_operand.sv
module fdiv_operand #(
  parameter int W = 4
) (
  input  logic [W-1:0] value,
  input  logic         is_signed,
  output logic [W-1:0] magnitude,
  output logic         negative
);
  assign negative  = is_signed & value[W-1];
  assign magnitude = negative ? (~value + 1'b1) : value;
endmodule

// File: rtl/fdiv_core.sv
module fdiv_core #(
  parameter int DW = 4,
  parameter int VW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [DW-1:0] num_mag,
  input  logic [VW-1:0] den_mag,
  output logic          last,
  output logic [DW-1:0] quo_mag,
  output logic [VW-1:0] rem_mag
);
  localparam int CW = $clog2(DW + 1);

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] quo_q;
  logic [VW-1:0] rem_q;
  logic [VW-1:0] den_q;
  logic [VW:0]   trial;
  logic          fits;

  assign trial = {rem_q, quo_q[DW-1]};
  assign fits  = trial >= {1'b0, den_q};
  assign last  = (cnt_q == CW'(DW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      quo_q <= '0;
      rem_q <= '0;
      den_q <= '0;
    end else if (load) begin
      cnt_q <= '0;
      quo_q <= num_mag;
      rem_q <= '0;
      den_q <= den_mag;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
      quo_q <= {quo_q[DW-2:0], fits};
      rem_q <= fits ? VW'(trial - {1'b0, den_q}) : trial[VW-1:0];
    end
  end

  assign quo_mag = quo_q;
  assign rem_mag = rem_q;

  // R5: partial remainder stays below a nonzero divisor while stepping
  a_r5_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    step && (den_q != '0) |-> rem_q < den_q);
endmodule

// File: rtl/fdiv_fixup.sv
module fdiv_fixup #(
  parameter int DW = 4,
  parameter int VW = 4
) (
  input  logic [DW-1:0] quo_mag,
  input  logic [VW-1:0] rem_mag,
  input  logic          num_neg,
  input  logic          den_neg,
  input  logic [VW-1:0] den_raw,
  input  logic          den_signed,
  output logic [DW:0]   quotient,
  output logic [VW-1:0] remainder
);
  logic [DW:0] q_trunc;
  logic [VW:0] r_trunc;
  logic [VW:0] den_ext;
  logic        den_zero;
  logic        adjust;

  always_comb begin
    den_zero = (den_raw == '0);
    den_ext  = {den_signed & den_raw[VW-1], den_raw};
    q_trunc  = (num_neg ^ den_neg) ? -{1'b0, quo_mag} : {1'b0, quo_mag};
    r_trunc  = num_neg ? -{1'b0, rem_mag} : {1'b0, rem_mag};
    adjust   = (rem_mag != '0) && (num_neg != den_neg);
    if (den_zero) begin
      quotient  = '0;
      remainder = '0;
    end else if (adjust) begin
      quotient  = q_trunc - 1'b1;
      remainder = VW'(r_trunc + den_ext);
    end else begin
      quotient  = q_trunc;
      remainder = r_trunc[VW-1:0];
    end
  end
endmodule

// File: rtl/fdiv_floor_unit.sv
module fdiv_floor_unit #(
  parameter int DW = 4,
  parameter int VW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_dividend,
  input  logic          in_dividend_signed,
  input  logic [VW-1:0] in_divisor,
  input  logic          in_divisor_signed,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW:0]   out_quotient,
  output logic [VW-1:0] out_remainder
);
  import fdiv_pkg::*;
  localparam int LW = $clog2(DW + 1) + 1;

  fdiv_state_e   state_q;
  logic          accept;
  logic          core_last;
  logic [DW-1:0] num_mag, quo_mag;
  logic [VW-1:0] den_mag, rem_mag;
  logic          num_neg, den_neg;
  logic          num_neg_q, den_neg_q, den_signed_q;
  logic [VW-1:0] den_raw_q;
  logic [LW-1:0] lat_q;

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_DONE);
  assign accept    = in_valid && in_ready;

  fdiv_operand #(.W(DW)) u_num (
    .value(in_dividend), .is_signed(in_dividend_signed),
    .magnitude(num_mag), .negative(num_neg));

  fdiv_operand #(.W(VW)) u_den (
    .value(in_divisor), .is_signed(in_divisor_signed),
    .magnitude(den_mag), .negative(den_neg));

  fdiv_core #(.DW(DW), .VW(VW)) u_core (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(state_q == ST_BUSY),
    .num_mag(num_mag), .den_mag(den_mag), .last(core_last),
    .quo_mag(quo_mag), .rem_mag(rem_mag));

  fdiv_fixup #(.DW(DW), .VW(VW)) u_fix (
    .quo_mag(quo_mag), .rem_mag(rem_mag), .num_neg(num_neg_q),
    .den_neg(den_neg_q), .den_raw(den_raw_q), .den_signed(den_signed_q),
    .quotient(out_quotient), .remainder(out_remainder));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      num_neg_q    <= 1'b0;
      den_neg_q    <= 1'b0;
      den_signed_q <= 1'b0;
      den_raw_q    <= '0;
      lat_q        <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q      <= ST_BUSY;
          num_neg_q    <= num_neg;
          den_neg_q    <= den_neg;
          den_signed_q <= in_divisor_signed;
          den_raw_q    <= in_divisor;
          lat_q        <= '0;
        end
        ST_BUSY: begin
          lat_q <= lat_q + 1'b1;
          if (core_last) state_q <= ST_DONE;
        end
        ST_DONE: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1: never accepting input while a result waits
  a_r1_ready_excl_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  // R2: stalled result holds still
  a_r2_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_quotient) && $stable(out_remainder));
  // R2: taken result frees the input side
  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> in_ready && !out_valid);
  // R3: result appears after exactly DW steps
  a_r3_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> lat_q == LW'(DW));
  // R5: signed nonzero remainder follows divisor sign
  a_r5_rem_sign: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && den_signed_q && (out_remainder != '0) |-> out_remainder[VW-1] == den_raw_q[VW-1]);
  // R7: zero divisor gives zero result
  a_r7_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (den_raw_q == '0) |-> (out_quotient == '0) && (out_remainder == '0));
endmodule

// File: tb/fdiv_floor_unit_test.sv
module fdiv_floor_unit_test;
  localparam int DW = 4;
  localparam int VW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_dividend = '0;
  logic          in_dividend_signed = 1'b0;
  logic [VW-1:0] in_divisor = '0;
  logic          in_divisor_signed = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW:0]   out_quotient;
  logic [VW-1:0] out_remainder;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  fdiv_floor_unit #(.DW(DW), .VW(VW)) uut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int to_int(input logic [7:0] v, input int w, input bit sgn);
    int x = int'(v) & ((1 << w) - 1);
    if (sgn && x >= (1 << (w - 1))) x -= (1 << w);
    return x;
  endfunction

  // floor reference by search: q with b*q <= a < b*(q+1) (b>0), reversed for b<0
  task automatic ref_div(input int a, input int b, output int q, output int r);
    q = 0; r = 0;
    if (b != 0) begin
      for (int t = -64; t <= 64; t++) begin
        if ((b > 0 && b * t <= a && a < b * (t + 1)) ||
            (b < 0 && b * t >= a && a > b * (t + 1))) q = t;
      end
      r = a - b * q;
    end
  endtask

  task automatic run_op(input int a, input bit sa, input int b, input bit sb,
                        output logic [DW:0] q, output logic [VW-1:0] r, output int lat);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_dividend = DW'(a); in_dividend_signed = sa;
    in_divisor = VW'(b); in_divisor_signed = sb;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid) begin @(negedge clk); lat++; end
    q = out_quotient; r = out_remainder;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic op_check(input string tag, input int a, input bit sa, input int b, input bit sb);
    logic [DW:0] q; logic [VW-1:0] r; int lat, eq, er, av, bv;
    av = to_int(8'(a), DW, sa); bv = to_int(8'(b), VW, sb);
    ref_div(av, bv, eq, er);
    run_op(a, sa, b, sb, q, r, lat);
    checks++;
    if (q != (DW+1)'(eq) || r != VW'(er)) begin
      fails++;
      $display("FAIL %s %0d/%0d (s%0d%0d) actual q=%0d r=%0d expected q=%0d r=%0d",
               tag, av, bv, sa, sb, to_int(8'(q), DW+1, 1), int'(r), eq, er & ((1 << VW) - 1));
    end
  endtask

  task automatic t_reset;
    chk("R9 in_ready after reset", int'(in_ready), 1);
    chk("R9 out_valid after reset", int'(out_valid), 0);
  endtask

  task automatic t_examples;
    logic [DW:0] q; logic [VW-1:0] r; int lat;
    run_op(-5, 1, 2, 1, q, r, lat);  chk("R4 -5/2", to_int(8'(q), DW+1, 1), -3);
    run_op(-5, 1, -2, 1, q, r, lat); chk("R4 -5/-2", to_int(8'(q), DW+1, 1), 2);
    run_op(5, 1, 2, 1, q, r, lat);   chk("R4 5/2", to_int(8'(q), DW+1, 1), 2);
    run_op(5, 1, -2, 1, q, r, lat);  chk("R4 5/-2", to_int(8'(q), DW+1, 1), -3);
    run_op(-5, 1, 3, 1, q, r, lat);  chk("R5 -5 mod 3", to_int(8'(r), VW, 1), 1);
    run_op(-5, 1, -3, 1, q, r, lat); chk("R5 -5 mod -3", to_int(8'(r), VW, 1), -2);
    run_op(5, 1, 3, 1, q, r, lat);   chk("R5 5 mod 3", to_int(8'(r), VW, 1), 2);
    run_op(5, 1, -3, 1, q, r, lat);  chk("R5 5 mod -3", to_int(8'(r), VW, 1), -1);
    run_op(-5, 1, 3, 0, q, r, lat);  chk("R6 signed mod unsigned", int'(r), 1);
    chk("R3 latency", lat, DW);
  endtask

  task automatic t_zero;
    logic [DW:0] q; logic [VW-1:0] r; int lat;
    run_op(-7, 1, 0, 1, q, r, lat);
    chk("R7 quotient", int'(q), 0); chk("R7 remainder", int'(r), 0); chk("R7 latency", lat, DW);
  endtask

  task automatic t_minneg;
    logic [DW:0] q; logic [VW-1:0] r; int lat;
    run_op(-(1 << (DW - 1)), 1, -1, 1, q, r, lat);
    chk("R8 quotient", to_int(8'(q), DW+1, 1), 1 << (DW - 1));
    chk("R8 remainder", int'(r), 0);
  endtask

  task automatic t_backpressure;
    logic [DW:0] q0; logic [VW-1:0] r0;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_dividend = DW'(7); in_dividend_signed = 1'b0;
    in_divisor = VW'(2); in_divisor_signed = 1'b0;
    @(negedge clk);
    chk("R1 in_ready low while busy", int'(in_ready), 0);
    in_dividend = DW'(-8); in_divisor = VW'(3); in_dividend_signed = 1'b1;
    while (!out_valid) @(negedge clk);
    q0 = out_quotient; r0 = out_remainder;
    chk("R1 busy operands ignored q", int'(q0), 3);
    chk("R1 busy operands ignored r", int'(r0), 1);
    repeat (3) @(negedge clk);
    chk("R2 valid held", int'(out_valid), 1);
    chk("R2 quotient held", int'(out_quotient), int'(q0));
    chk("R2 in_ready low while stalled", int'(in_ready), 0);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R2 out_valid dropped", int'(out_valid), 0);
    chk("R2 in_ready back", int'(in_ready), 1);
  endtask

  task automatic t_exhaustive;
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < (1 << DW); a++)
        for (int b = 0; b < (1 << VW); b++)
          op_check("R4/R5/R6/R7 sweep", a, m[0], b, m[1]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_examples();
    t_zero();
    t_minneg();
    t_backpressure();
    t_exhaustive();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=below 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule